// File: doc/BRIEF.md
# Audio Clock Divider

This block turns a single module clock into the three clocks an audio serial port needs: a master clock for an external converter, a serial bit clock, and a frame (left/right) clock. The master and bit clocks each come from a programmable divider. Each divider is steered by a 4-bit code that selects a ratio from a fixed, non-linear table rather than holding a binary divide value. The frame clock is derived from the bit clock and changes level once every 32 bit-clock periods, so a stereo frame spans 64 bit clocks.

A 9-bit control word carries both divider codes and an enable for the master-clock output. With a 24.576 MHz module clock, bit-clock code 5 (ratio 8) gives a 3.072 MHz bit clock and a 48 kHz frame clock. A new code never cuts a period short. It is taken up only when the running period ends, so the outputs carry no runt pulses.

Top module: `aud_clk_gen`

## Requirements
- R1: Code values 1 to 15 select the ratios 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176 and 192 in that order. An active ratio N gives an output period of N module-clock cycles.
- R2: For every ratio of 2 or more, the output is high for the first N/2 cycles of each period and low for the remaining N/2. It goes high in the cycle that follows the edge on which the ratio was loaded.
- R3: Ratio 1 passes the module clock straight through to the output.
- R4: Code 0 holds its output low with no toggling. On the bit-clock divider, code 0 also freezes the frame clock at its current level.
- R5: Control bit 8 enables the master-clock output. While it is 0, the master clock reads low whatever its code. Clearing or setting the bit takes effect without waiting for a period boundary.
- R6: The master-clock code sits in control bits 3:0 and the bit-clock code in bits 7:4. The two dividers run independently of each other.
- R7: A changed code is loaded on the first clock edge after the running period ends. From the idle state (code 0 active), it is loaded on the next edge.
- R8: The frame clock changes level on the edge that ends every 32nd bit-clock period after the bit clock was loaded. It starts low, which gives 48 kHz for bit-clock code 5 on a 24.576 MHz module clock.
- R9: A synchronous active-high reset sets both dividers idle and drives all three outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ctl | input | 9 | Control: [3:0] master code, [7:4] bit code, [8] master enable |
| mclk_o | output | 1 | Master clock output |
| bclk_o | output | 1 | Serial bit clock |
| fclk_o | output | 1 | Frame clock, 64 bit clocks per stereo frame |

## Verification
A code driven while a divider is idle passes through one register, so the new level first shows in the sample taken after the next edge, e+1. The period then spans e+1 to e+N, and the frame clock first flips after edge e+32N+1. The master enable has no register in its path, so its effect is due in the very next half-cycle sample. Each expectation is queued against an absolute edge index and a clock phase. The monitor samples 5 ns after every rising and falling edge, which also catches the pass-through ratio while the clock is high and while it is low.

// File: rtl/aud_clkdiv_pkg.sv
package aud_clkdiv_pkg;

    localparam int CODE_W  = 4;
    localparam int RATIO_W = 8;
    localparam int CHAN_N  = 2;   // 0: master clock, 1: bit clock

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    // Control word: enable in the top bit, bit-clock code, master-clock code.
    typedef struct packed {
        logic  mclk_en;
        code_t bclk_code;
        code_t mclk_code;
    } div_ctl_t;

    localparam int CTL_W = $bits(div_ctl_t);

    // Non-linear code-to-ratio mapping; code 0 means idle.
    function automatic ratio_t code_to_ratio(input code_t code);
        ratio_t r;
        case (code)
            4'd1:    r = 8'd1;
            4'd2:    r = 8'd2;
            4'd3:    r = 8'd4;
            4'd4:    r = 8'd6;
            4'd5:    r = 8'd8;
            4'd6:    r = 8'd12;
            4'd7:    r = 8'd16;
            4'd8:    r = 8'd24;
            4'd9:    r = 8'd32;
            4'd10:   r = 8'd48;
            4'd11:   r = 8'd64;
            4'd12:   r = 8'd96;
            4'd13:   r = 8'd128;
            4'd14:   r = 8'd176;
            4'd15:   r = 8'd192;
            default: r = 8'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aud_ratio_div.sv
module aud_ratio_div
    import aud_clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  code_t  code_i,
    output logic   div_o,
    output logic   bound_o,
    output ratio_t ratio_o
);

    ratio_t cur_q;
    ratio_t cnt_q;
    ratio_t new_ratio;
    ratio_t cnt_nx;
    logic   level_q;
    logic   at_bound;

    assign new_ratio = code_to_ratio(code_i);
    assign cnt_nx    = cnt_q + 1'b1;

    // A period ends on its last count; an idle divider is always at a boundary.
    assign at_bound = (cur_q == '0) || (cnt_q == cur_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (at_bound) begin
            cur_q   <= new_ratio;
            cnt_q   <= '0;
            level_q <= (new_ratio >= ratio_t'(2));
        end else begin
            cnt_q   <= cnt_nx;
            level_q <= (cnt_nx < (cur_q >> 1));
        end
    end

    assign div_o   = level_q;
    assign bound_o = at_bound;
    assign ratio_o = cur_q;

endmodule

// File: rtl/aud_frame_gen.sv
module aud_frame_gen #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic fclk_o
);

    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt_q;
    logic         lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                lvl_q <= ~lvl_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fclk_o = lvl_q;

endmodule

// File: rtl/aud_clk_gen.sv
module aud_clk_gen
    import aud_clkdiv_pkg::*;
#(
    parameter int FRAME_HALF = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] div_ctl,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             fclk_o
);

    div_ctl_t ctl_s;
    code_t    code_a  [CHAN_N];
    logic     div_a   [CHAN_N];
    logic     bound_a [CHAN_N];
    ratio_t   ratio_a [CHAN_N];
    logic     pass_a  [CHAN_N];
    logic     bclk_tick;

    assign ctl_s     = div_ctl_t'(div_ctl);
    assign code_a[0] = ctl_s.mclk_code;
    assign code_a[1] = ctl_s.bclk_code;

    for (genvar g = 0; g < CHAN_N; g++) begin : g_div
        aud_ratio_div u_div (
            .clk     (clk),
            .rst     (rst),
            .code_i  (code_a[g]),
            .div_o   (div_a[g]),
            .bound_o (bound_a[g]),
            .ratio_o (ratio_a[g])
        );
        assign pass_a[g] = (ratio_a[g] == ratio_t'(1));
    end

    // One bit-clock period has completed on this edge.
    assign bclk_tick = bound_a[1] && (ratio_a[1] != '0);

    aud_frame_gen #(.HALF(FRAME_HALF)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick_i (bclk_tick),
        .fclk_o (fclk_o)
    );

    assign mclk_o = ctl_s.mclk_en & (pass_a[0] ? clk : div_a[0]);
    assign bclk_o = pass_a[1] ? clk : div_a[1];

endmodule

// File: rtl/aud_clk_gen_chk.sv
module aud_clk_gen_chk
    import aud_clkdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   bclk_o,
    input logic   fclk_o,
    input ratio_t m_ratio,
    input logic   m_bound,
    input ratio_t b_ratio,
    input logic   b_bound,
    input logic   b_tick
);

    p_mload_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(m_ratio) |-> $past(m_bound));

    p_bload_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(b_ratio) |-> $past(b_bound));

    p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
        (b_ratio == '0) |-> !bclk_o);

    p_rise_bound_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_o) |-> $past(b_bound));

    p_frame_tick_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(fclk_o) |-> $past(b_tick));

    p_reset_low_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bclk_o && !fclk_o));

endmodule

bind aud_clk_gen aud_clk_gen_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .bclk_o  (bclk_o),
    .fclk_o  (fclk_o),
    .m_ratio (ratio_a[0]),
    .m_bound (bound_a[0]),
    .b_ratio (ratio_a[1]),
    .b_bound (bound_a[1]),
    .b_tick  (bclk_tick)
);

// File: tb/test_aud_clk_gen.sv
module test_aud_clk_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] div_ctl = 9'h000;
    logic       mclk_o, bclk_o, fclk_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int    c;
        bit    ph;    // 0: after rising edge, 1: after falling edge
        int    sig;   // 0 mclk, 1 bclk, 2 fclk
        bit    val;
        string req;
    } exp_t;

    exp_t sb[$];

    aud_clk_gen i_aud_clk_gen (
        .clk     (clk),
        .rst     (rst),
        .div_ctl (div_ctl),
        .mclk_o  (mclk_o),
        .bclk_o  (bclk_o),
        .fclk_o  (fclk_o)
    );

    initial forever #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Ratio table as stated in R1.
    function automatic int ratio_of(input int code);
        case (code)
            1: return 1;    2: return 2;    3: return 4;    4: return 6;
            5: return 8;    6: return 12;   7: return 16;   8: return 24;
            9: return 32;   10: return 48;  11: return 64;  12: return 96;
            13: return 128; 14: return 176; 15: return 192;
            default: return 0;
        endcase
    endfunction

    function automatic bit sig_val(input int s);
        case (s)
            0: return mclk_o;
            1: return bclk_o;
            default: return fclk_o;
        endcase
    endfunction

    function automatic string sig_name(input int s);
        case (s)
            0: return "mclk";
            1: return "bclk";
            default: return "fclk";
        endcase
    endfunction

    task automatic push(input int c, input bit ph, input int sig, input bit v, input string req);
        exp_t it;
        int   i;
        it.c = c; it.ph = ph; it.sig = sig; it.val = v; it.req = req;
        i = sb.size();
        while (i > 0 && (sb[i-1].c * 2 + int'(sb[i-1].ph)) > (c * 2 + int'(ph))) i--;
        sb.insert(i, it);
    endtask

    task automatic exp_range(input int sig, input int c0, input int c1,
                             input bit vh, input bit vl, input string req);
        for (int k = c0; k <= c1; k++) begin
            push(k, 1'b0, sig, vh, req);
            push(k, 1'b1, sig, vl, req);
        end
    endtask

    // Divider loaded on edge e+1 with ratio r (>= 2).
    task automatic exp_period(input int sig, input int e, input int r, input string req);
        push(e + 1,         1'b0, sig, 1'b1, req);
        push(e + r / 2,     1'b0, sig, 1'b1, req);
        push(e + r / 2,     1'b1, sig, 1'b1, req);
        push(e + r / 2 + 1, 1'b0, sig, 1'b0, req);
        push(e + r,         1'b0, sig, 1'b0, req);
        push(e + r + 1,     1'b0, sig, 1'b1, req);
    endtask

    task automatic check_phase(input bit ph);
        while (sb.size() > 0 &&
               (sb[0].c * 2 + int'(sb[0].ph)) <= (cyc * 2 + int'(ph))) begin
            exp_t it;
            bit   act;
            it  = sb.pop_front();
            act = sig_val(it.sig);
            n_checks++;
            if (it.c != cyc || it.ph != ph) begin
                n_fail++;
                $display("FAIL %s: %s check for edge %0d phase %0d missed (now %0d) actual=%0b expected=%0b",
                         it.req, sig_name(it.sig), it.c, it.ph, cyc, act, it.val);
            end else if (act !== it.val) begin
                n_fail++;
                $display("FAIL %s: %s at edge %0d phase %0d actual=%0b expected=%0b",
                         it.req, sig_name(it.sig), it.c, it.ph, act, it.val);
            end
        end
    endtask

    // Monitor: samples 5 ns after each rising and each falling edge.
    initial forever begin
        @(posedge clk); #5 check_phase(1'b0);
        @(negedge clk); #5 check_phase(1'b1);
    end

    task automatic apply(input bit en, input int bc, input int mc, output int e);
        @(negedge clk);
        div_ctl = {en, 4'(bc), 4'(mc)};
        e = cyc;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        div_ctl = 9'h000;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int e;

        // R9: outputs low throughout reset, even with a non-zero control word.
        div_ctl = {1'b1, 4'd5, 4'd1};
        repeat (2) @(negedge clk);
        e = cyc;
        for (int s = 0; s < 3; s++) exp_range(s, e + 1, e + 3, 1'b0, 1'b0, "R9");
        repeat (4) @(negedge clk);
        div_ctl = 9'h000;
        @(negedge clk);
        rst = 1'b0;

        // R4: both codes 0 with enable set, all outputs stay low.
        apply(1'b1, 0, 0, e);
        for (int s = 0; s < 3; s++) exp_range(s, e + 1, e + 6, 1'b0, 1'b0, "R4");
        drain();

        // R3: master code 1 passes the module clock through; bit clock stays idle (R4).
        apply(1'b1, 0, 1, e);
        exp_range(0, e + 1, e + 6, 1'b1, 1'b0, "R3");
        exp_range(1, e + 1, e + 6, 1'b0, 1'b0, "R4");
        drain();

        // R5: enable cleared gates the master clock at once, then restored.
        apply(1'b0, 0, 1, e);
        exp_range(0, e + 1, e + 4, 1'b0, 1'b0, "R5");
        drain();
        apply(1'b1, 0, 1, e);
        exp_range(0, e + 1, e + 2, 1'b1, 1'b0, "R5");
        drain();

        // R1/R2/R6: every even ratio on the master field, a different one on the bit field.
        for (int c = 2; c <= 15; c++) begin
            do_reset();
            apply(1'b1, 17 - c, c, e);
            exp_period(0, e, ratio_of(c), "R1");
            exp_period(1, e, ratio_of(17 - c), "R6");
            push(e + ratio_of(c) / 2 + 1, 1'b1, 0, 1'b0, "R2");
            drain();
        end

        // R7: change mid-period; old ratio 6 completes, new ratio 4 follows.
        do_reset();
        apply(1'b0, 4, 0, e);
        push(e + 3, 1'b0, 1, 1'b1, "R7");
        push(e + 4, 1'b0, 1, 1'b0, "R7");
        push(e + 6, 1'b0, 1, 1'b0, "R7");
        push(e + 7, 1'b0, 1, 1'b1, "R7");
        push(e + 8, 1'b0, 1, 1'b1, "R7");
        push(e + 9, 1'b0, 1, 1'b0, "R7");
        push(e + 10, 1'b0, 1, 1'b0, "R7");
        push(e + 11, 1'b0, 1, 1'b1, "R7");
        repeat (2) @(negedge clk);
        div_ctl = {1'b0, 4'd3, 4'd0};
        drain();

        // R8: bit code 5 (ratio 8) gives a frame level change every 256 cycles.
        do_reset();
        apply(1'b0, 5, 0, e);
        exp_period(1, e, 8, "R8");
        push(e + 256, 1'b0, 2, 1'b0, "R8");
        push(e + 257, 1'b0, 2, 1'b1, "R8");
        push(e + 512, 1'b0, 2, 1'b1, "R8");
        push(e + 513, 1'b0, 2, 1'b0, "R8");
        drain();

        // R4: bit code 0 stops the bit clock and freezes the frame clock.
        apply(1'b0, 0, 0, e);
        exp_range(1, e + 10, e + 40, 1'b0, 1'b0, "R4");
        for (int k = e + 10; k <= e + 300; k += 10) push(k, 1'b0, 2, 1'b0, "R4");
        drain();

        summary();
        $finish;
    end

endmodule